// File: doc/BRIEF.md
# Host-to-PCI Configuration Cycle Decoder

This block sits inside a host bridge and turns host I/O accesses to the two configuration ports into configuration requests. A full 32-bit write to the address port (byte address 0xCF8) loads a configuration address register. An access to the data port (byte address 0xCFC) is then classified against that register and against two programmable bus-number registers. One register holds the number of the PCI bus directly below the bridge. The other holds the highest bus number reachable through it. The classifier produces one of four outcomes: an internal access to a host-bus device, a Type 0 cycle, a Type 1 cycle, or no claim.

A claimed data-port access leaves the block as one request on the configuration side. The request carries the outcome code, the translated address and the host's byte enables, and it is held until it is acknowledged. Every accepted host access gets exactly one response pulse. The pulse reports whether the access was claimed and, for reads, the data.

A single control state machine sequences each access. In ST_IDLE the host port is ready; a request is captured, which is the *accept* transition to ST_DECODE. In ST_DECODE the access is classified and any address-port write is committed. From there the *forward* transition goes to ST_ISSUE for a claimed data-port access, and the *settle* transition goes to ST_REPLY for anything else. ST_ISSUE holds the configuration request until cfg_ack, which is the *complete* transition to ST_REPLY. ST_REPLY drives the response for one cycle and takes the *retire* transition back to ST_IDLE.

Top module: `cfg_cycle_decoder`

## Requirements
- R1: After reset the address register, both bus-number registers and all response and request valids are zero, and req_ready is 1. An address-port read then returns 0x00000000 and is claimed. A data-port read is unclaimed and returns 0xFFFFFFFF.
- R2: The address port is claimed only when all four byte enables are set. A claimed write stores enable [31], bus [23:16], device [15:11], function [10:8] and register [7:2]. Bits [30:24] and [1:0] read back as 0. A partial access to the address port is unclaimed, returns 0xFFFFFFFF on a read, and leaves the register unchanged.
- R3: A data-port access while address bit 31 is 0 is unclaimed and issues no configuration request.
- R4: Bus 0 with device number equal to SELF_DEV issues cfg_kind 1 (internal). Its address is {8'h00, bus, device, function, register, 2'b00}. This holds whatever own-bus value is programmed. Other devices 16 to 31 on bus 0 are not claimed.
- R5: A bus equal to the own-bus register with device 0 to 15 issues cfg_kind 2 (Type 0). Its address is {one-hot select at bit 16+device over [31:16], 5'b0, function, register, 2'b00}.
- R6: A bus above the own-bus register and not above the subordinate register issues cfg_kind 3 (Type 1). Its address is {8'h00, bus, device, function, register, 2'b01}.
- R7: A data-port access that matches none of R4 to R6 is unclaimed. It issues no request, a read returns 0xFFFFFFFF, and a write is discarded.
- R8: An issued request carries the host access's byte enables, write flag and write data unchanged.
- R9: cfg_valid and its fields are held steady until cfg_ack. A read response returns the cfg_rdata sampled with cfg_ack, and write responses return 0. rsp_valid is a single-cycle pulse per accepted access, and req_ready is 1 only in ST_IDLE.
- R10: Accesses to any I/O dword other than the two ports are unclaimed, and reads of them return 0xFFFFFFFF.
- R11: A cycle with busnum_we set loads both bus-number registers, and the next access is classified with the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host I/O access present |
| req_ready | output | 1 | Block can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | IO_AW-2 | Dword I/O address (byte address bits IO_AW-1:2) |
| req_be | input | 4 | Host byte enables |
| req_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_claimed | output | 1 | Access was claimed |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| busnum_we | input | 1 | Load bus-number registers |
| busnum_own | input | 8 | New own-bus number |
| busnum_sub | input | 8 | New subordinate-bus number |
| cfg_valid | output | 1 | Configuration request pending |
| cfg_ack | input | 1 | Request completed |
| cfg_kind | output | 2 | 1 internal, 2 Type 0, 3 Type 1 |
| cfg_addr | output | 32 | Translated configuration address |
| cfg_be | output | 4 | Byte enables of the request |
| cfg_write | output | 1 | Request is a write |
| cfg_wdata | output | 32 | Request write data |
| cfg_rdata | input | 32 | Completion read data |

## Verification
The bench builds the block with SELF_DEV set to 19 instead of 16, and keeps the default port addresses. With that setting, devices 16, 17 and 18 on bus 0 become host-bus devices that this bridge must not claim, so the R4 rule that only the bridge's own device number is claimed is exercised directly. The own-bus and subordinate values are reprogrammed during the run, including own bus 0. This covers Type 0 on bus 0 next to internal claims, and the edges of the Type 1 range at subordinate and subordinate+1.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BE_W   = WORD_W / 8;
    localparam int unsigned BUS_W  = 8;
    localparam int unsigned DEV_W  = 5;
    localparam int unsigned FN_W   = 3;
    localparam int unsigned REG_W  = 6;
    localparam int unsigned IDSEL_W = 16;

    typedef enum logic [1:0] {
        KIND_NONE     = 2'd0,
        KIND_INTERNAL = 2'd1,
        KIND_TYPE0    = 2'd2,
        KIND_TYPE1    = 2'd3
    } cfg_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_ISSUE  = 2'd2,
        ST_REPLY  = 2'd3
    } ctrl_state_t;

    typedef enum logic [1:0] {
        PORT_OTHER     = 2'd0,
        PORT_ADDR_FULL = 2'd1,
        PORT_ADDR_PART = 2'd2,
        PORT_DATA      = 2'd3
    } port_sel_t;
endpackage

// File: rtl/ccd_addr_regs.sv
module ccd_addr_regs
    import ccd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [WORD_W-1:0] addr_wdata,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  own_in,
    input  logic [BUS_W-1:0]  sub_in,
    output logic [WORD_W-1:0] addr_q,
    output logic [BUS_W-1:0]  own_q,
    output logic [BUS_W-1:0]  sub_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_we) begin
            addr_q <= addr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q <= '0;
            sub_q <= '0;
        end else if (bus_we) begin
            own_q <= own_in;
            sub_q <= sub_in;
        end
    end
endmodule

// File: rtl/ccd_classify.sv
module ccd_classify
    import ccd_pkg::*;
#(
    parameter logic [DEV_W-1:0] SELF_DEV = 5'd16
) (
    input  logic              en,
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FN_W-1:0]   fn,
    input  logic [REG_W-1:0]  rg,
    input  logic [BUS_W-1:0]  own_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    output cfg_kind_t         kind,
    output logic [WORD_W-1:0] xaddr
);
    localparam int unsigned IDX_W = $clog2(IDSEL_W);

    logic [IDSEL_W-1:0] idsel;

    for (genvar g = 0; g < IDSEL_W; g++) begin : g_idsel
        assign idsel[g] = (dev[IDX_W-1:0] == IDX_W'(g));
    end

    logic local_dev;
    assign local_dev = (dev < DEV_W'(IDSEL_W));

    always_comb begin
        kind = KIND_NONE;
        if (en) begin
            if (bus == '0 && dev == SELF_DEV) begin
                kind = KIND_INTERNAL;
            end else if (bus == own_bus && local_dev) begin
                kind = KIND_TYPE0;
            end else if (bus > own_bus && bus <= sub_bus) begin
                kind = KIND_TYPE1;
            end
        end
    end

    always_comb begin
        unique case (kind)
            KIND_INTERNAL: xaddr = {8'h00, bus, dev, fn, rg, 2'b00};
            KIND_TYPE0:    xaddr = {idsel, 5'b00000, fn, rg, 2'b00};
            KIND_TYPE1:    xaddr = {8'h00, bus, dev, fn, rg, 2'b01};
            default:       xaddr = '0;
        endcase
    end
endmodule

// File: rtl/ccd_ctrl.sv
module ccd_ctrl
    import ccd_pkg::*;
#(
    parameter int unsigned       IO_AW     = 16,
    parameter logic [IO_AW-1:0]  ADDR_PORT = 16'hCF8,
    parameter logic [IO_AW-1:0]  DATA_PORT = 16'hCFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [IO_AW-1:2]  req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_claimed,
    output logic [WORD_W-1:0] rsp_rdata,
    input  cfg_kind_t         kind_in,
    input  logic [WORD_W-1:0] xaddr_in,
    input  logic [WORD_W-1:0] addr_q,
    output logic              addr_we,
    output logic [WORD_W-1:0] addr_wdata,
    output logic              cfg_valid,
    input  logic              cfg_ack,
    output cfg_kind_t         cfg_kind,
    output logic [WORD_W-1:0] cfg_addr,
    output logic [BE_W-1:0]   cfg_be,
    output logic              cfg_write,
    output logic [WORD_W-1:0] cfg_wdata,
    input  logic [WORD_W-1:0] cfg_rdata
);
    localparam logic [WORD_W-1:0] ALL_ONES = '1;
    localparam logic [BE_W-1:0]   FULL_BE  = '1;

    ctrl_state_t       state_q, state_d;
    port_sel_t         port_sel, port_q;
    logic              wr_q;
    logic [BE_W-1:0]   be_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] rdata_q;
    logic              claimed_q;
    cfg_kind_t         kind_q;
    logic [WORD_W-1:0] xaddr_q;
    logic              forward;

    always_comb begin
        if (req_addr == ADDR_PORT[IO_AW-1:2]) begin
            port_sel = (req_be == FULL_BE) ? PORT_ADDR_FULL : PORT_ADDR_PART;
        end else if (req_addr == DATA_PORT[IO_AW-1:2]) begin
            port_sel = PORT_DATA;
        end else begin
            port_sel = PORT_OTHER;
        end
    end

    assign forward = (port_q == PORT_DATA) && (kind_in != KIND_NONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_DECODE;         // accept
            ST_DECODE: state_d = forward ? ST_ISSUE : ST_REPLY;    // forward / settle
            ST_ISSUE:  if (cfg_ack) state_d = ST_REPLY;            // complete
            ST_REPLY:  state_d = ST_IDLE;                          // retire
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        rsp_valid   = (state_q == ST_REPLY);
        cfg_valid   = (state_q == ST_ISSUE);
        addr_we     = (state_q == ST_DECODE) && (port_q == PORT_ADDR_FULL) && wr_q;
        addr_wdata  = {wdata_q[31], 7'b0000000, wdata_q[23:2], 2'b00};
        rsp_claimed = claimed_q;
        rsp_rdata   = rdata_q;
        cfg_kind    = kind_q;
        cfg_addr    = xaddr_q;
        cfg_be      = be_q;
        cfg_write   = wr_q;
        cfg_wdata   = wdata_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q    <= PORT_OTHER;
            wr_q      <= 1'b0;
            be_q      <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            claimed_q <= 1'b0;
            kind_q    <= KIND_NONE;
            xaddr_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        port_q  <= port_sel;
                        wr_q    <= req_write;
                        be_q    <= req_be;
                        wdata_q <= req_wdata;
                    end
                end
                ST_DECODE: begin
                    kind_q  <= kind_in;
                    xaddr_q <= xaddr_in;
                    unique case (port_q)
                        PORT_ADDR_FULL: begin
                            claimed_q <= 1'b1;
                            rdata_q   <= wr_q ? '0 : addr_q;
                        end
                        PORT_DATA: begin
                            claimed_q <= forward;
                            rdata_q   <= (wr_q || forward) ? '0 : ALL_ONES;
                        end
                        default: begin
                            claimed_q <= 1'b0;
                            rdata_q   <= wr_q ? '0 : ALL_ONES;
                        end
                    endcase
                end
                ST_ISSUE: begin
                    if (cfg_ack && !wr_q) rdata_q <= cfg_rdata;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_cycle_decoder.sv
module cfg_cycle_decoder
    import ccd_pkg::*;
#(
    parameter int unsigned      IO_AW     = 16,
    parameter logic [IO_AW-1:0] ADDR_PORT = 16'hCF8,
    parameter logic [IO_AW-1:0] DATA_PORT = 16'hCFC,
    parameter logic [4:0]       SELF_DEV  = 5'd16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [IO_AW-1:2]  req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_claimed,
    output logic [31:0]       rsp_rdata,
    input  logic              busnum_we,
    input  logic [7:0]        busnum_own,
    input  logic [7:0]        busnum_sub,
    output logic              cfg_valid,
    input  logic              cfg_ack,
    output logic [1:0]        cfg_kind,
    output logic [31:0]       cfg_addr,
    output logic [3:0]        cfg_be,
    output logic              cfg_write,
    output logic [31:0]       cfg_wdata,
    input  logic [31:0]       cfg_rdata
);
    logic [WORD_W-1:0] addr_q;
    logic [BUS_W-1:0]  own_bus_q;
    logic [BUS_W-1:0]  sub_bus_q;
    logic              addr_we;
    logic [WORD_W-1:0] addr_wdata;
    cfg_kind_t         kind;
    cfg_kind_t         kind_out;
    logic [WORD_W-1:0] xaddr;

    ccd_addr_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_we    (addr_we),
        .addr_wdata (addr_wdata),
        .bus_we     (busnum_we),
        .own_in     (busnum_own),
        .sub_in     (busnum_sub),
        .addr_q     (addr_q),
        .own_q      (own_bus_q),
        .sub_q      (sub_bus_q)
    );

    ccd_classify #(.SELF_DEV(SELF_DEV)) u_cls (
        .en      (addr_q[31]),
        .bus     (addr_q[23:16]),
        .dev     (addr_q[15:11]),
        .fn      (addr_q[10:8]),
        .rg      (addr_q[7:2]),
        .own_bus (own_bus_q),
        .sub_bus (sub_bus_q),
        .kind    (kind),
        .xaddr   (xaddr)
    );

    ccd_ctrl #(
        .IO_AW     (IO_AW),
        .ADDR_PORT (ADDR_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_be      (req_be),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_claimed (rsp_claimed),
        .rsp_rdata   (rsp_rdata),
        .kind_in     (kind),
        .xaddr_in    (xaddr),
        .addr_q      (addr_q),
        .addr_we     (addr_we),
        .addr_wdata  (addr_wdata),
        .cfg_valid   (cfg_valid),
        .cfg_ack     (cfg_ack),
        .cfg_kind    (kind_out),
        .cfg_addr    (cfg_addr),
        .cfg_be      (cfg_be),
        .cfg_write   (cfg_write),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata)
    );

    assign cfg_kind = kind_out;
endmodule

// File: rtl/ccd_checker.sv
module ccd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        cfg_valid,
    input logic        cfg_ack,
    input logic [1:0]  cfg_kind,
    input logic [31:0] cfg_addr,
    input logic [3:0]  cfg_be
);
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_ack |=> cfg_valid && $stable(cfg_addr) && $stable(cfg_kind) && $stable(cfg_be)); // R9

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready); // R9

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cfg_valid && !rsp_valid); // R9

    AST_TYPE0_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_kind == 2'd2 |->
            cfg_addr[1:0] == 2'b00 && cfg_addr[15:11] == 5'd0 && $countones(cfg_addr[31:16]) == 1); // R5

    AST_TYPE1_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_kind == 2'd3 |-> cfg_addr[1:0] == 2'b01 && cfg_addr[31:24] == 8'd0); // R6

    AST_INTERNAL_BUS0: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_kind == 2'd1 |-> cfg_addr[23:16] == 8'd0 && cfg_addr[1:0] == 2'b00); // R4

    AST_NO_EMPTY_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> cfg_kind != 2'd0); // R7
endmodule

bind cfg_cycle_decoder ccd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .cfg_valid (cfg_valid),
    .cfg_ack   (cfg_ack),
    .cfg_kind  (cfg_kind),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be)
);

// File: tb/cfg_cycle_decoder_tb.sv
module cfg_cycle_decoder_tb;
    localparam logic [4:0] SELF = 5'd19;
    localparam logic [15:0] PA = 16'hCF8;
    localparam logic [15:0] PD = 16'hCFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:2] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_claimed;
    logic [31:0] rsp_rdata;
    logic        busnum_we = 1'b0;
    logic [7:0]  busnum_own = '0, busnum_sub = '0;
    logic        cfg_valid, cfg_write;
    logic        cfg_ack = 1'b0;
    logic [1:0]  cfg_kind;
    logic [31:0] cfg_addr, cfg_wdata;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_rdata = '0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] m_addr = '0;
    logic [7:0]  m_own = '0, m_sub = '0;

    always #5 clk = ~clk;

    cfg_cycle_decoder #(.SELF_DEV(SELF)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_claimed(rsp_claimed), .rsp_rdata(rsp_rdata),
        .busnum_we(busnum_we), .busnum_own(busnum_own), .busnum_sub(busnum_sub),
        .cfg_valid(cfg_valid), .cfg_ack(cfg_ack), .cfg_kind(cfg_kind),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_write(cfg_write),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_kind(logic [31:0] a, logic [7:0] own, logic [7:0] sub);
        logic [7:0] b = a[23:16];
        logic [4:0] d = a[15:11];
        if (!a[31]) return 2'd0;
        if (b == 8'd0 && d == SELF) return 2'd1;
        if (b == own && d <= 5'd15) return 2'd2;
        if (b > own && b <= sub) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [31:0] exp_xaddr(logic [31:0] a, logic [1:0] k);
        logic [15:0] sel = 16'(1) << a[14:11];
        case (k)
            2'd1:    return {8'h00, a[23:2], 2'b00};
            2'd2:    return {sel, 5'd0, a[10:2], 2'b00};
            2'd3:    return {8'h00, a[23:2], 2'b01};
            default: return 32'h0;
        endcase
    endfunction

    task automatic access(input logic wr, input logic [15:0] port, input logic [3:0] be,
                          input logic [31:0] wd, input logic [31:0] resp, input int delay,
                          output bit got_cfg, output logic [1:0] g_kind, output logic [31:0] g_addr,
                          output logic [3:0] g_be, output logic g_wr, output logic [31:0] g_wd,
                          output logic g_claim, output logic [31:0] g_rdata);
        int cnt = delay;
        got_cfg = 1'b0;
        g_kind = '0; g_addr = '0; g_be = '0; g_wr = 1'b0; g_wd = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = port[15:2]; req_be = be; req_wdata = wd;
        cfg_rdata = resp;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        forever begin
            cfg_ack = 1'b0;
            if (rsp_valid) begin
                g_claim = rsp_claimed; g_rdata = rsp_rdata;
                break;
            end
            if (cfg_valid) begin
                if (!got_cfg) begin
                    got_cfg = 1'b1;
                    g_kind = cfg_kind; g_addr = cfg_addr; g_be = cfg_be; g_wr = cfg_write; g_wd = cfg_wdata;
                end else begin
                    chk("R9 hold", cfg_addr, g_addr);
                end
                if (cnt == 0) cfg_ack = 1'b1;
                else cnt--;
            end
            @(negedge clk);
        end
        @(negedge clk);
        chk("R9 pulse", {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    task automatic set_bus(input logic [7:0] own, input logic [7:0] sub);
        @(negedge clk);
        busnum_we = 1'b1; busnum_own = own; busnum_sub = sub;
        @(negedge clk);
        busnum_we = 1'b0;
        m_own = own; m_sub = sub;
    endtask

    task automatic write_addr(input logic [31:0] v);
        bit gc; logic [1:0] k; logic [31:0] a, wd2, rd; logic [3:0] b; logic w, c;
        access(1'b1, PA, 4'hF, v, 32'h0, 0, gc, k, a, b, w, wd2, c, rd);
        chk("R2 addr claim", {31'd0, c}, 32'd1);
        chk("R2 addr no cfg", {31'd0, gc}, 32'd0);
        m_addr = {v[31], 7'd0, v[23:2], 2'b00};
    endtask

    task automatic read_addr(input string tag);
        bit gc; logic [1:0] k; logic [31:0] a, wd2, rd; logic [3:0] b; logic w, c;
        access(1'b0, PA, 4'hF, 32'h0, 32'h0, 0, gc, k, a, b, w, wd2, c, rd);
        chk(tag, rd, m_addr);
        chk(tag, {31'd0, c}, 32'd1);
    endtask

    task automatic data_op(input logic wr, input logic [3:0] be, input logic [31:0] wd,
                           input logic [31:0] resp, input int delay, input string tag);
        bit gc; logic [1:0] k; logic [31:0] a, gwd, rd; logic [3:0] b; logic w, c;
        logic [1:0] ek = exp_kind(m_addr, m_own, m_sub);
        access(wr, PD, be, wd, resp, delay, gc, k, a, b, w, gwd, c, rd);
        chk({tag, " claim"}, {31'd0, c}, {31'd0, ek != 2'd0});
        chk({tag, " issued"}, {31'd0, gc}, {31'd0, ek != 2'd0});
        if (ek != 2'd0) begin
            chk({tag, " kind"}, {30'd0, k}, {30'd0, ek});
            chk({tag, " addr"}, a, exp_xaddr(m_addr, ek));
            chk("R8 be", {28'd0, b}, {28'd0, be});
            chk("R8 write", {31'd0, w}, {31'd0, wr});
            if (wr) chk("R8 wdata", gwd, wd);
            chk("R9 rdata", rd, wr ? 32'h0 : resp);
        end else begin
            chk("R7 rdata", rd, wr ? 32'h0 : 32'hFFFF_FFFF);
        end
    endtask

    function automatic logic [31:0] mk(logic en, logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [5:0] r);
        return {en, 7'd0, b, d, f, r, 2'b00};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit gc; logic [1:0] k; logic [31:0] a, gwd, rd; logic [3:0] b; logic w, c;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        chk("R1 reset idle", {29'd0, req_ready, rsp_valid, cfg_valid}, 32'd4);
        rst_n = 1'b1;
        read_addr("R1 addr reset");
        data_op(1'b0, 4'hF, 0, 32'h1234_5678, 0, "R1 data reset");

        set_bus(8'd2, 8'd5);
        // R2: partial access ignored
        access(1'b1, PA, 4'h3, 32'h8002_0800, 0, 0, gc, k, a, b, w, gwd, c, rd);
        chk("R2 partial claim", {31'd0, c}, 32'd0);
        access(1'b0, PA, 4'h1, 0, 0, 0, gc, k, a, b, w, gwd, c, rd);
        chk("R2 partial read", rd, 32'hFFFF_FFFF);
        read_addr("R2 partial kept");
        write_addr(32'hFFFF_FFFF);
        chk("R2 readback mask", m_addr, 32'h80FF_FFFC);
        read_addr("R2 readback");

        write_addr(mk(1, 8'd0, SELF, 3'd3, 6'd5));
        data_op(1'b0, 4'hF, 0, 32'hCAFE_0001, 1, "R4 internal");
        write_addr(mk(1, 8'd0, 5'd16, 3'd0, 6'd1));
        data_op(1'b0, 4'hF, 0, 32'h1, 0, "R4 other hostdev");
        write_addr(mk(1, 8'd2, 5'd15, 3'd7, 6'd63));
        data_op(1'b1, 4'h6, 32'hA5A5_5A5A, 0, 2, "R5 type0 dev15");
        write_addr(mk(1, 8'd2, 5'd0, 3'd1, 6'd2));
        data_op(1'b0, 4'hF, 0, 32'h0BAD_F00D, 0, "R5 type0 dev0");
        write_addr(mk(1, 8'd2, 5'd16, 3'd0, 6'd0));
        data_op(1'b1, 4'hF, 32'h1, 0, 0, "R7 dev16 own bus");
        write_addr(mk(1, 8'd3, 5'd9, 3'd2, 6'd4));
        data_op(1'b0, 4'hF, 0, 32'h3333_3333, 0, "R6 type1 low");
        write_addr(mk(1, 8'd5, 5'd31, 3'd7, 6'd1));
        data_op(1'b1, 4'h8, 32'hFFEE_DDCC, 0, 1, "R6 type1 sub");
        write_addr(mk(1, 8'd6, 5'd1, 3'd0, 6'd0));
        data_op(1'b0, 4'hF, 0, 32'h0, 0, "R7 above sub");
        write_addr(mk(1, 8'd1, 5'd1, 3'd0, 6'd0));
        data_op(1'b0, 4'hF, 0, 32'h0, 0, "R7 below own");
        write_addr(mk(0, 8'd2, 5'd1, 3'd0, 6'd0));
        data_op(1'b0, 4'hF, 0, 32'h0, 0, "R3 disabled");
        access(1'b0, 16'h0CF4, 4'hF, 0, 0, 0, gc, k, a, b, w, gwd, c, rd);
        chk("R10 other port", rd, 32'hFFFF_FFFF);
        chk("R10 other claim", {31'd0, c, gc}, 32'd0);

        set_bus(8'd0, 8'd3);
        write_addr(mk(1, 8'd0, 5'd4, 3'd0, 6'd8));
        data_op(1'b0, 4'hF, 0, 32'h4444_0000, 0, "R11 R5 own bus0");
        write_addr(mk(1, 8'd0, SELF, 3'd0, 6'd8));
        data_op(1'b0, 4'hF, 0, 32'h5555_0000, 0, "R11 R4 internal bus0");
        set_bus(8'd7, 8'd9);
        data_op(1'b1, 4'h1, 32'h77, 0, 0, "R11 R4 own reprog");

        for (int i = 0; i < 400; i++) begin
            logic [7:0] bus;
            logic [4:0] dev;
            int sel;
            if ($urandom_range(0, 9) == 0) begin
                logic [7:0] o = 8'($urandom_range(0, 10));
                set_bus(o, o + 8'($urandom_range(0, 5)));
            end
            sel = $urandom_range(0, 5);
            case (sel)
                0: bus = 8'd0;
                1: bus = m_own;
                2: bus = m_own + 8'd1;
                3: bus = m_sub;
                4: bus = m_sub + 8'd1;
                default: bus = 8'($urandom);
            endcase
            sel = $urandom_range(0, 2);
            dev = (sel == 0) ? SELF : (sel == 1) ? 5'($urandom_range(0, 15)) : 5'($urandom);
            write_addr({($urandom_range(0, 7) != 0), 7'($urandom), bus, dev, 3'($urandom), 6'($urandom), 2'($urandom)});
            data_op(1'($urandom), 4'($urandom), $urandom, $urandom, $urandom_range(0, 2), "R4 R5 R6 R7 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule